// File: doc/BRIEF.md
# Parallel Flash Bus Mode Controller

This block is a clock-synchronous model of the host side of a parallel NOR flash device. It samples the active-low chip-select (`ceN`), output-enable (`oeN`), write-strobe (`weN`) and reset/power-down (`rpN`) pins through two-flop synchronizers. It decides when the data bus is driven and which of four read sources drives it: the storage array, the identifier table, the status byte or the query table.

Bytes written on the bus are decoded as commands that switch the read source or start a program or whole-array erase. The storage is a small internal register file. The program/erase engine is modelled as a busy interval with a fixed cycle count. While that interval runs, every read returns status and new commands are dropped.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While `rpN` is low the block drives nothing (`dataOe`=0), clears `busy` and aborts any operation. After `rpN` returns high, and after `rstN`, reads come from the array and status reads 0x80. Array contents are kept across `rpN`, and `rstN` fills the array with 0xFF.
- R2: `dataOe` is 1 only while `ceN` and `oeN` are low and `weN` and `rpN` are high. It follows the pins after two clock edges. While `dataOe` is 0, `dataOut` is 0. This covers standby (`ceN` high, whatever `oeN` is).
- R3: A bus write is a period in which `ceN` and `weN` are low and `oeN` is high. It is taken once, with the `addr` and `dataIn` present when the first of `weN` or `ceN` rises. Strobes with `oeN` low are not writes.
- R4: Command 0xFF selects array reads, 0x90 identifier, 0x70 status and 0x98 query. Any byte that is not a command selects array reads.
- R5: In identifier mode, address 0 reads 0x5A, address 1 reads 0xC3 and all other addresses read 0x00.
- R6: In query mode, addresses 0, 1 and 2 read 0x51, 0x52 and 0x59, and all other addresses read 0x00.
- R7: Command 0x40 followed by a write of D to address A sets word A to (old AND D). `busy` is then high for exactly PROG_CYCLES clocks.
- R8: Command 0x20 followed by 0xD0 sets every word to 0xFF and holds `busy` high for exactly ERASE_CYCLES clocks. Any other second byte cancels the erase, changes no word and selects array reads.
- R9: Status bit 7 is 1 when ready and 0 when busy, and the other bits are 0. While `busy` is high, reads return status in every mode. After `busy` falls, the mode in force before the operation returns.
- R10: Writes that end while `busy` is high are ignored.
- R11: `activePower` is 1 while `ceN` is low or `busy` is high. Raising `ceN` during an operation keeps it at 1 until `busy` falls.
- R12: Command writes never change array contents, at any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| ceN | input | 1 | Chip select, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| weN | input | 1 | Write strobe, active low, asynchronous |
| rpN | input | 1 | Reset/power-down, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data from host |
| dataOut | output | DATA_W | Read data to host, 0 when not driven |
| dataOe | output | 1 | Data bus drive enable |
| busy | output | 1 | Program or erase interval in progress |
| activePower | output | 1 | Device not in standby |

## Verification
The assertions assume that `addr` and `dataIn` stay stable from the start of a write strobe until at least three clocks after the terminating rising edge. The pins are sampled through synchronizers, so the command is taken at that later time. They also assume that each pin level lasts at least two clocks, so the synchronizers see every transition. The bench holds the address and data for its whole write and read tasks and keeps every pin level for three or more clocks. That keeps the latched byte and the synchronized strobes consistent with what the pins show.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2,
    RD_QUERY  = 2'd3
  } readMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      progWr;
    logic      eraseAll;
    logic      outEn;
    logic      showStatus;
    readMode_e mode;
  } dpStrobe_t;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_RD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
endpackage

// File: rtl/flash_pin_sync.sv
module flash_pin_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);
  logic [WIDTH-1:0] stageA;

  // all pins are active low, so the idle value is 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA  <= '1;
      pinSync <= '1;
    end else begin
      stageA  <= pinIn;
      pinSync <= stageA;
    end
  end
endmodule

// File: rtl/flash_bus_ctl.sv
module flash_bus_ctl
  import flash_bus_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              rpN,
  input  logic [DATA_W-1:0] dataIn,
  output dpStrobe_t         strb,
  output logic              busy,
  output logic              activePower
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {CS_IDLE, CS_PROG, CS_ERASE} cmdState_e;

  logic [3:0] pinSync;
  logic       ceS, oeS, weS, rpS;
  logic       wrLvl, wrPrev, wrEnd, accept;
  logic [CNT_W-1:0] busyCnt;
  cmdState_e  cmdState;
  readMode_e  readMode;

  flash_pin_sync #(.WIDTH(4)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  ({rpN, weN, oeN, ceN}),
    .pinSync(pinSync)
  );
  assign {rpS, weS, oeS, ceS} = pinSync;

  // write period and its end (first of WE/CE rising)
  assign wrLvl  = !ceS && !weS && oeS;
  assign wrEnd  = wrPrev && (ceS || weS) && rpS;
  assign busy   = (busyCnt != '0);
  assign accept = wrEnd && !busy;

  always_comb begin
    strb.progWr     = accept && (cmdState == CS_PROG);
    strb.eraseAll   = accept && (cmdState == CS_ERASE) && (dataIn == DATA_W'(CMD_CONFIRM));
    strb.outEn      = !ceS && !oeS && weS && rpS;
    strb.showStatus = busy;
    strb.mode       = readMode;
  end

  assign activePower = !ceS || busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      busyCnt  <= '0;
      cmdState <= CS_IDLE;
      readMode <= RD_ARRAY;
    end else if (!rpS) begin
      wrPrev   <= 1'b0;
      busyCnt  <= '0;
      cmdState <= CS_IDLE;
      readMode <= RD_ARRAY;
    end else begin
      wrPrev <= wrLvl;
      if (busy) busyCnt <= busyCnt - 1'b1;
      if (accept) begin
        case (cmdState)
          CS_PROG: begin
            busyCnt  <= CNT_W'(PROG_CYCLES);
            cmdState <= CS_IDLE;
          end
          CS_ERASE: begin
            cmdState <= CS_IDLE;
            if (dataIn == DATA_W'(CMD_CONFIRM)) busyCnt <= CNT_W'(ERASE_CYCLES);
            else readMode <= RD_ARRAY;
          end
          default: begin
            if      (dataIn == DATA_W'(CMD_RD_ARRAY))  readMode <= RD_ARRAY;
            else if (dataIn == DATA_W'(CMD_RD_IDENT))  readMode <= RD_IDENT;
            else if (dataIn == DATA_W'(CMD_RD_STATUS)) readMode <= RD_STATUS;
            else if (dataIn == DATA_W'(CMD_RD_QUERY))  readMode <= RD_QUERY;
            else if (dataIn == DATA_W'(CMD_PROG))      cmdState <= CS_PROG;
            else if (dataIn == DATA_W'(CMD_ERASE))     cmdState <= CS_ERASE;
            else                                       readMode <= RD_ARRAY;
          end
        endcase
      end
    end
  end

  // R1: a low reset pin leaves array mode and no operation
  assert_rp_default_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rpS |=> (readMode == RD_ARRAY && !busy));

  // R7 / R8: busy only starts right after an accepted write
  assert_busy_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEnd));

  // R10: a write ending while busy changes neither mode nor command state
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEnd) |=> ($stable(readMode) && $stable(cmdState)));

  // R11: an operation keeps the block out of standby
  assert_power_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt > CNT_W'(1) && rpS) |=> activePower);
endmodule

// File: rtl/flash_bus_dp.sv
module flash_bus_dp
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] statusByte;

  function automatic logic [DATA_W-1:0] identWord(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(0): identWord = DATA_W'(8'h5A);
      ADDR_W'(1): identWord = DATA_W'(8'hC3);
      default:    identWord = '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] queryWord(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_W'(0): queryWord = DATA_W'(8'h51);
      ADDR_W'(1): queryWord = DATA_W'(8'h52);
      ADDR_W'(2): queryWord = DATA_W'(8'h59);
      default:    queryWord = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.eraseAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.progWr) begin
      mem[addr] <= mem[addr] & dataIn;
    end
  end

  assign statusByte = {!strb.showStatus, {(DATA_W-1){1'b0}}};

  always_comb begin
    if (!strb.outEn)                                    dataOut = '0;
    else if (strb.showStatus || strb.mode == RD_STATUS) dataOut = statusByte;
    else if (strb.mode == RD_IDENT)                     dataOut = identWord(addr);
    else if (strb.mode == RD_QUERY)                     dataOut = queryWord(addr);
    else                                                dataOut = mem[addr];
  end

  // R7: programming only clears bits
  assert_prog_and_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.progWr |=> (mem[$past(addr)] == ($past(mem[addr]) & $past(dataIn))));

  // R8: erase fills the first and last word
  assert_erase_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseAll |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              rpN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              activePower
);
  dpStrobe_t strb;

  flash_bus_ctl #(
    .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .rpN(rpN),
    .dataIn(dataIn), .strb(strb), .busy(busy), .activePower(activePower)
  );

  flash_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut)
  );

  assign dataOe = strb.outEn;
endmodule

// File: tb/flash_bus_ctrl_tb.sv
module flash_bus_ctrl_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int PROG_N = 8;
  localparam int ERASE_N = 40;

  logic clk = 0, rstN = 0;
  logic ceN = 1, oeN = 1, weN = 1, rpN = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic dataOe, busy, activePower;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_bus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_N),
                   .ERASE_CYCLES(ERASE_N)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .rpN(rpN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .busy(busy), .activePower(activePower));

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input bit ceFirst = 0);
    addr = a; dataIn = d; oeN = 1;
    ceN = 0; weN = 0; waitN(3);
    if (ceFirst) begin ceN = 1; waitN(4); weN = 1; end
    else begin weN = 1; waitN(4); ceN = 1; end
    waitN(3);
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, input string req, input int exp);
    addr = a; ceN = 0; oeN = 0; waitN(4);
    check(req, dataOe, 1);
    check(req, dataOut, exp);
    oeN = 1; ceN = 1; waitN(3);
  endtask

  // write then count the clocks with busy high
  task automatic writeMeasure(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                              output int n);
    addr = a; dataIn = d; oeN = 1;
    ceN = 0; weN = 0; waitN(3);
    weN = 1; n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy) n++;
      else if (n > 0) break;
    end
    ceN = 1; waitN(3);
  endtask

  task automatic testReset();
    check("R1 busy after reset", busy, 0);
    check("R2 idle dataOe", dataOe, 0);
    check("R11 idle power", activePower, 0);
    busRead(4'd0, "R1 array default", 8'hFF);
    busWrite(4'd0, 8'h70);
    busRead(4'd0, "R9 ready status", 8'h80);
    busWrite(4'd0, 8'hFF);
  endtask

  task automatic testGating();
    ceN = 0; oeN = 1; waitN(4);
    check("R2 oe high", dataOe, 0);
    check("R2 oe high data", dataOut, 0);
    check("R11 ce low power", activePower, 1);
    ceN = 1; oeN = 0; waitN(4);
    check("R2 standby", dataOe, 0);
    check("R2 standby data", dataOut, 0);
    check("R11 standby power", activePower, 0);
    ceN = 0; weN = 0; waitN(4);
    check("R2 we low", dataOe, 0);
    weN = 1; rpN = 0; waitN(4);
    check("R1 rp low no drive", dataOe, 0);
    rpN = 1; waitN(4);
    check("R2 drive after rp", dataOe, 1);
    ceN = 1; oeN = 1; waitN(3);
  endtask

  task automatic testModes();
    busWrite(4'd3, 8'h90);
    busRead(4'd0, "R5 ident 0", 8'h5A);
    busRead(4'd1, "R5 ident 1", 8'hC3);
    busRead(4'd2, "R5 ident other", 8'h00);
    busWrite(4'd3, 8'h98);
    busRead(4'd0, "R6 query 0", 8'h51);
    busRead(4'd1, "R6 query 1", 8'h52);
    busRead(4'd2, "R6 query 2", 8'h59);
    busRead(4'd3, "R6 query other", 8'h00);
    busWrite(4'd3, 8'h70);
    busRead(4'd9, "R4 status mode", 8'h80);
    busWrite(4'd3, 8'h33);
    busRead(4'd3, "R12 command left array", 8'hFF);
    busRead(4'd0, "R4 unknown selects array", 8'hFF);
  endtask

  task automatic testProgram();
    int n;
    busWrite(4'd5, 8'h40);
    writeMeasure(4'd5, 8'h3C, n);
    check("R7 program busy length", n, PROG_N);
    busRead(4'd5, "R7 program value", 8'h3C);
    busWrite(4'd5, 8'h40);
    busWrite(4'd5, 8'hF0);
    waitN(PROG_N + 2);
    busRead(4'd5, "R7 program AND", 8'h30);
    busRead(4'd4, "R7 neighbour intact", 8'hFF);
  endtask

  task automatic testEraseCancel();
    busWrite(4'd0, 8'h90);
    busWrite(4'd0, 8'h20);
    busWrite(4'd0, 8'h55);
    check("R8 cancel not busy", busy, 0);
    busRead(4'd5, "R8 cancel keeps data/array mode", 8'h30);
  endtask

  task automatic testCeFirst();
    busWrite(4'd0, 8'h90, 1);
    busRead(4'd0, "R3 ce-terminated write", 8'h5A);
    addr = 4'd0; dataIn = 8'hFF; ceN = 0; oeN = 0; weN = 0; waitN(4);
    weN = 1; waitN(2); ceN = 1; oeN = 1; waitN(4);
    busRead(4'd0, "R3 oe low is not a write", 8'h5A);
    busWrite(4'd0, 8'hFF);
  endtask

  task automatic testEraseLen();
    int n;
    busWrite(4'd0, 8'h20);
    writeMeasure(4'd0, 8'hD0, n);
    check("R8 erase busy length", n, ERASE_N);
    busRead(4'd5, "R8 erased word", 8'hFF);
  endtask

  task automatic testBusyReads();
    busWrite(4'd0, 8'h90);
    busWrite(4'd0, 8'h20);
    busWrite(4'd0, 8'hD0);
    check("R11 power held with ce high", activePower, 1);
    check("R8 busy during erase", busy, 1);
    busRead(4'd0, "R9 status while busy", 8'h00);
    busWrite(4'd0, 8'hFF);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    waitN(1);
    check("R11 standby after op", activePower, 0);
    busRead(4'd0, "R10 ignored write / R9 mode back", 8'h5A);
    busWrite(4'd0, 8'hFF);
  endtask

  task automatic testRpAbort();
    busWrite(4'd0, 8'h90);
    busWrite(4'd0, 8'h20);
    busWrite(4'd0, 8'hD0);
    check("R8 busy before abort", busy, 1);
    rpN = 0; waitN(4);
    check("R1 abort clears busy", busy, 0);
    rpN = 1; waitN(3);
    busRead(4'd0, "R1 array after rp", 8'hFF);
    busWrite(4'd0, 8'h70);
    busRead(4'd0, "R1 status 0x80 after rp", 8'h80);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    waitN(3);
    rstN = 1;
    waitN(3);
    testReset();
    testGating();
    testModes();
    testProgram();
    testEraseCancel();
    testCeFirst();
    testEraseLen();
    testBusyReads();
    testRpAbort();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule